// File: doc/BRIEF.md
# NAND Flash Command Responder

This block models the device end of an 8-bit asynchronous NAND flash bus for two operations: product identification and device reset. A host drives the chip enable, command latch, address latch, write enable and read enable strobes. The block samples them with the system clock and takes in a command or address byte on each rising edge of write enable. After the identification command and a zero address, successive read enable pulses return a maker byte and then a device code. The device code is a parameter.

A reset command aborts any operation in progress. It holds the ready/busy output low for a number of system clocks set by a parameter and reloads the status register. The status value depends on the write-protect input. A reset command written while the device is still in its reset state is refused. A behavioural operation input stands in for an array operation that a reset can abort. It holds ready/busy low for a parameter-set number of clocks.

Top module: `nand_cmd_responder`

## Requirements
- R1: A byte is taken as a command on a rising edge of write enable when chip enable is low, command latch is high and address latch is low. It is taken as an address when chip enable is low, address latch is high and command latch is low. With chip enable high, a write edge has no effect.
- R2: Command 90h followed by address byte 00h enters identification mode. Any other address byte after 90h returns the block to idle.
- R3: In identification mode, the first read returns ECh and the second returns DEV_CODE. Every later read also returns DEV_CODE. The read position advances on the rising edge of read enable.
- R4: io_oe is high only while chip enable and read enable are both low in identification mode. io_out is 00h whenever io_oe is low.
- R5: Identification mode persists across reads until a new command byte is accepted. Command 90h restarts the sequence. An unknown command byte returns the block to idle.
- R6: An accepted reset command (FFh) drives rb_n low for exactly TRST_CLKS clock cycles, after which rb_n returns high.
- R7: The status output is C0h after power-on. An accepted reset loads C0h when wp_n is high and 40h when wp_n is low.
- R8: The block enters its reset state at power-on or when a reset is accepted. It leaves that state when a command byte or an operation is accepted. A reset command written while the block is in its reset state is ignored: rb_n stays high and the status is unchanged.
- R9: A pulse on op_start while the block is ready holds rb_n low for OP_CLKS cycles. A reset written during that time ends the operation at once, and rb_n then stays low for TRST_CLKS cycles only.
- R10: While a reset is counting down, command and address bytes are ignored, so identification mode cannot be entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write enable, bytes taken on its rising edge |
| re_n | input | 1 | Read enable, active low |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Byte written by the host |
| op_start | input | 1 | One-clock pulse that starts a behavioural busy operation |
| io_out | output | 8 | Byte returned to the host |
| io_oe | output | 1 | Output enable for io_out |
| rb_n | output | 1 | Ready (high) or busy (low) |
| status | output | 8 | Status register |

## Verification
The bench builds the block with DEV_CODE set to 45h. This keeps the device byte distinct from the default and from the maker byte. TRST_CLKS is set to 40, which is long enough for a full command and address write to fit inside the reset window, so the commands that R10 says are ignored can be written while the reset is still counting down. OP_CLKS is set to 300. This makes an aborted operation clearly shorter than a complete one, and the exact lengths of both busy windows can be counted at the rb_n pin.

// File: rtl/nand_resp_pkg.sv
package nand_resp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ID_ADDR = 2'd1,
    ST_ID_READ = 2'd2
  } id_state_e;

  typedef struct packed {
    logic       ce_n;
    logic       cle;
    logic       ale;
    logic       we_n;
    logic       re_n;
    logic       wp_n;
    logic [7:0] io;
  } pin_bus_t;

  localparam pin_bus_t PINS_QUIET = '{ce_n: 1'b1, cle: 1'b0, ale: 1'b0,
                                      we_n: 1'b1, re_n: 1'b1, wp_n: 1'b1,
                                      io: 8'h00};

  localparam logic [7:0] OPC_IDENT   = 8'h90;
  localparam logic [7:0] OPC_RESET   = 8'hFF;
  localparam logic [7:0] IDENT_ADDR  = 8'h00;
  localparam logic [7:0] MAKER_BYTE  = 8'hEC;
  localparam logic [7:0] STAT_WP_HI  = 8'hC0;
  localparam logic [7:0] STAT_WP_LO  = 8'h40;

endpackage

// File: rtl/nand_pin_sync.sv
module nand_pin_sync
  import nand_resp_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  pin_bus_t raw,
  output pin_bus_t pins,
  output logic     we_rise,
  output logic     re_rise
);

  pin_bus_t stage_q [STAGES];
  logic     we_prev_q;
  logic     re_prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= PINS_QUIET;
        else        stage_q[g] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= PINS_QUIET;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign pins = stage_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_prev_q <= 1'b1;
      re_prev_q <= 1'b1;
    end else begin
      we_prev_q <= pins.we_n;
      re_prev_q <= pins.re_n;
    end
  end

  assign we_rise = pins.we_n & ~we_prev_q;
  assign re_rise = pins.re_n & ~re_prev_q;

endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int TRST_CLKS = 40,
  parameter int OP_CLKS   = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_go,
  input  logic op_go,
  output logic rst_busy,
  output logic op_busy
);

  localparam int RW = $clog2(TRST_CLKS + 1);
  localparam int OW = $clog2(OP_CLKS + 1);
  localparam logic [RW-1:0] RST_LOAD = RW'(TRST_CLKS);
  localparam logic [OW-1:0] OP_LOAD  = OW'(OP_CLKS);

  logic [RW-1:0] rst_cnt_q, rst_cnt_d;
  logic [OW-1:0] op_cnt_q,  op_cnt_d;

  always_comb begin
    rst_cnt_d = rst_cnt_q;
    op_cnt_d  = op_cnt_q;
    if (rst_go) begin
      rst_cnt_d = RST_LOAD;
      op_cnt_d  = '0;
    end else begin
      if (rst_cnt_q != '0) rst_cnt_d = rst_cnt_q - 1'b1;
      if (op_go)               op_cnt_d = OP_LOAD;
      else if (op_cnt_q != '0) op_cnt_d = op_cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_cnt_q <= '0;
      op_cnt_q  <= '0;
    end else begin
      rst_cnt_q <= rst_cnt_d;
      op_cnt_q  <= op_cnt_d;
    end
  end

  assign rst_busy = (rst_cnt_q != '0);
  assign op_busy  = (op_cnt_q != '0);

  // R6: the reset window shrinks by one each cycle until reloaded
  p_rst_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_cnt_q != '0 && !rst_go) |=> (rst_cnt_q == $past(rst_cnt_q) - 1'b1));

  // R9: an accepted reset ends the operation and opens a full reset window
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_go |=> (op_cnt_q == '0 && rst_cnt_q == RST_LOAD));

endmodule

// File: rtl/nand_cmd_fsm.sv
module nand_cmd_fsm
  import nand_resp_pkg::*;
#(
  parameter logic [7:0] DEV_CODE = 8'h75
) (
  input  logic       clk,
  input  logic       rst_n,
  input  pin_bus_t   pins,
  input  logic       we_rise,
  input  logic       re_rise,
  input  logic       op_start,
  input  logic       rst_busy,
  input  logic       op_busy,
  output logic       rst_go,
  output logic       op_go,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic [7:0] status
);

  id_state_e  state_q, state_d;
  logic       rd_idx_q, rd_idx_d;
  logic       in_rst_q, in_rst_d;
  logic [7:0] stat_q, stat_d;

  logic cmd_strobe, addr_strobe, busy_any, cmd_ok, is_reset;

  assign cmd_strobe  = we_rise & ~pins.ce_n & pins.cle & ~pins.ale;
  assign addr_strobe = we_rise & ~pins.ce_n & pins.ale & ~pins.cle;
  assign busy_any    = rst_busy | op_busy;
  assign is_reset    = (pins.io == OPC_RESET);
  assign rst_go      = cmd_strobe & is_reset & ~in_rst_q & ~rst_busy;
  assign cmd_ok      = cmd_strobe & ~is_reset & ~busy_any;
  assign op_go       = op_start & ~busy_any & ~rst_go & ~cmd_ok;

  always_comb begin
    state_d  = state_q;
    rd_idx_d = rd_idx_q;
    in_rst_d = in_rst_q;
    stat_d   = stat_q;
    if (rst_go) begin
      state_d  = ST_IDLE;
      rd_idx_d = 1'b0;
      in_rst_d = 1'b1;
      stat_d   = pins.wp_n ? STAT_WP_HI : STAT_WP_LO;
    end else if (cmd_ok) begin
      in_rst_d = 1'b0;
      rd_idx_d = 1'b0;
      state_d  = (pins.io == OPC_IDENT) ? ST_ID_ADDR : ST_IDLE;
    end else if (addr_strobe && !busy_any && state_q == ST_ID_ADDR) begin
      rd_idx_d = 1'b0;
      state_d  = (pins.io == IDENT_ADDR) ? ST_ID_READ : ST_IDLE;
    end else if (re_rise && !pins.ce_n && state_q == ST_ID_READ) begin
      rd_idx_d = 1'b1;
    end
    if (op_go) in_rst_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      rd_idx_q <= 1'b0;
      in_rst_q <= 1'b1;
      stat_q   <= STAT_WP_HI;
    end else begin
      state_q  <= state_d;
      rd_idx_q <= rd_idx_d;
      in_rst_q <= in_rst_d;
      stat_q   <= stat_d;
    end
  end

  assign io_oe  = (state_q == ST_ID_READ) & ~pins.ce_n & ~pins.re_n;
  assign io_out = !io_oe ? 8'h00 : (rd_idx_q ? DEV_CODE : MAKER_BYTE);
  assign status = stat_q;

  // R2: read mode is entered only from the address-wait state
  p_id_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ID_READ && $past(state_q) != ST_ID_READ)
      |-> $past(state_q) == ST_ID_ADDR);

  // R7: status only changes on the cycle after an accepted reset
  p_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_q) |-> $past(rst_go));

  // R10: an idle block stays idle while the reset window runs
  p_busy_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_busy && state_q == ST_IDLE) |=> state_q == ST_IDLE);

  // R3: once past the maker byte, the read position does not go back while reading
  p_idx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx_q && state_q == ST_ID_READ && !cmd_strobe && !addr_strobe)
      |=> rd_idx_q);

endmodule

// File: rtl/nand_cmd_responder.sv
module nand_cmd_responder
  import nand_resp_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         TRST_CLKS   = 40,
  parameter int         OP_CLKS     = 300,
  parameter logic [7:0] DEV_CODE    = 8'h75
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       wp_n,
  input  logic [7:0] io_in,
  input  logic       op_start,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic       rb_n,
  output logic [7:0] status
);

  pin_bus_t raw_pins, pins;
  logic     we_rise, re_rise;
  logic     rst_go, op_go, rst_busy, op_busy;

  assign raw_pins = '{ce_n: ce_n, cle: cle, ale: ale, we_n: we_n,
                      re_n: re_n, wp_n: wp_n, io: io_in};

  nand_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw     (raw_pins),
    .pins    (pins),
    .we_rise (we_rise),
    .re_rise (re_rise)
  );

  nand_cmd_fsm #(.DEV_CODE(DEV_CODE)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .pins     (pins),
    .we_rise  (we_rise),
    .re_rise  (re_rise),
    .op_start (op_start),
    .rst_busy (rst_busy),
    .op_busy  (op_busy),
    .rst_go   (rst_go),
    .op_go    (op_go),
    .io_out   (io_out),
    .io_oe    (io_oe),
    .status   (status)
  );

  nand_busy_timer #(.TRST_CLKS(TRST_CLKS), .OP_CLKS(OP_CLKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_go   (rst_go),
    .op_go    (op_go),
    .rst_busy (rst_busy),
    .op_busy  (op_busy)
  );

  assign rb_n = ~(rst_busy | op_busy);

  // R4: no byte is driven while the host holds read enable high
  p_oe_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (re_n && $past(re_n) && $past(re_n, 2) && $past(re_n, 3)) |-> !io_oe);

endmodule

// File: tb/nand_cmd_responder_tb.sv
module nand_cmd_responder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TRST       = 40;
  localparam int OPN        = 300;
  localparam logic [7:0] DEV = 8'h45;

  localparam logic [2:0] K_CMD = 3'd0, K_ADDR = 3'd1, K_RD = 3'd2,
                         K_CMD_NOCE = 3'd3, K_RD_NOCE = 3'd4;

  typedef struct packed {
    logic [2:0] kind;
    logic [7:0] data;
    logic       exp_oe;
    logic [7:0] exp_byte;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{K_CMD,  8'h90, 1'b0, 8'h00},  // R2 enter
    '{K_ADDR, 8'h00, 1'b0, 8'h00},  // R2
    '{K_RD,   8'h00, 1'b1, 8'hEC},  // R3 maker
    '{K_RD,   8'h00, 1'b1, DEV},    // R3 device
    '{K_RD,   8'h00, 1'b1, DEV},    // R3 repeat
    '{K_RD,   8'h00, 1'b1, DEV},    // R5 persists
    '{K_CMD,  8'h90, 1'b0, 8'h00},  // R5 restart
    '{K_ADDR, 8'h00, 1'b0, 8'h00},
    '{K_RD,   8'h00, 1'b1, 8'hEC},  // R5 restarted
    '{K_CMD,  8'h33, 1'b0, 8'h00},  // R5 unknown
    '{K_RD,   8'h00, 1'b0, 8'h00},  // R5 idle, R4 no drive
    '{K_CMD,  8'h90, 1'b0, 8'h00},
    '{K_ADDR, 8'h05, 1'b0, 8'h00},  // R2 wrong address
    '{K_RD,   8'h00, 1'b0, 8'h00},  // R2
    '{K_CMD,  8'h90, 1'b0, 8'h00},
    '{K_ADDR, 8'h00, 1'b0, 8'h00},
    '{K_RD_NOCE, 8'h00, 1'b0, 8'h00}, // R4 chip enable high
    '{K_RD,   8'h00, 1'b1, 8'hEC},  // R4 position not advanced
    '{K_CMD_NOCE, 8'h33, 1'b0, 8'h00}, // R1 ignored write
    '{K_RD,   8'h00, 1'b1, DEV}     // R1 still in mode
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] io_in = 8'h00;
  logic op_start = 1'b0;
  logic [7:0] io_out, status;
  logic io_oe, rb_n;

  int checks = 0, failures = 0, low_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (rst_n && !rb_n) low_cnt++;

  nand_cmd_responder #(.SYNC_STAGES(2), .TRST_CLKS(TRST), .OP_CLKS(OPN),
                       .DEV_CODE(DEV)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .op_start(op_start),
    .io_out(io_out), .io_oe(io_oe), .rb_n(rb_n), .status(status));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit is_cmd, input logic [7:0] b, input bit ce_low);
    ce_n = ~ce_low; cle = is_cmd; ale = ~is_cmd; io_in = b;
    clks(1); we_n = 1'b0; clks(4); we_n = 1'b1; clks(4);
    cle = 1'b0; ale = 1'b0; ce_n = 1'b1; clks(2);
  endtask

  task automatic rd(input bit ce_low, output logic oe, output logic [7:0] b);
    ce_n = ~ce_low; clks(1); re_n = 1'b0; clks(6);
    oe = io_oe; b = io_out;
    re_n = 1'b1; clks(5); ce_n = 1'b1; clks(2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic oe;
    logic [7:0] b;
    clks(3); rst_n = 1'b1; clks(3);
    chk(rb_n === 1'b1, "R6 reset rb_n", rb_n, 1);
    chk(io_oe === 1'b0, "R4 reset io_oe", io_oe, 0);
    chk(status === 8'hC0, "R7 power-on status", status, 8'hC0);

    low_cnt = 0; wr(1, 8'hFF, 1); clks(TRST + 10);
    chk(low_cnt == 0, "R8 reset at power-up ignored", low_cnt, 0);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].kind)
        K_CMD:      wr(1, VECS[i].data, 1);
        K_ADDR:     wr(0, VECS[i].data, 1);
        K_CMD_NOCE: wr(1, VECS[i].data, 0);
        default: begin
          rd(VECS[i].kind == K_RD, oe, b);
          chk(oe === VECS[i].exp_oe, $sformatf("R1/R2/R3/R4/R5 row %0d oe", i),
              oe, VECS[i].exp_oe);
          chk(b === VECS[i].exp_byte, $sformatf("R1/R2/R3/R4/R5 row %0d byte", i),
              b, VECS[i].exp_byte);
        end
      endcase
    end

    low_cnt = 0; wp_n = 1'b1; wr(1, 8'hFF, 1); clks(TRST + 10);
    chk(low_cnt == TRST, "R6 reset busy length", low_cnt, TRST);
    chk(rb_n === 1'b1, "R6 ready after reset", rb_n, 1);
    chk(status === 8'hC0, "R7 status wp high", status, 8'hC0);

    low_cnt = 0; wp_n = 1'b0; wr(1, 8'hFF, 1); clks(TRST + 10);
    chk(low_cnt == 0, "R8 second reset ignored", low_cnt, 0);
    chk(status === 8'hC0, "R8 status unchanged", status, 8'hC0);

    wr(1, 8'h90, 1);
    low_cnt = 0; wr(1, 8'hFF, 1);
    wr(1, 8'h90, 1); wr(0, 8'h00, 1);
    chk(rb_n === 1'b0, "R10 still busy during writes", rb_n, 0);
    clks(TRST + 10);
    rd(1, oe, b);
    chk(oe === 1'b0, "R10 ident ignored during reset", oe, 0);
    chk(low_cnt == TRST, "R6 reset length wp low", low_cnt, TRST);
    chk(status === 8'h40, "R7 status wp low", status, 8'h40);

    wp_n = 1'b1; low_cnt = 0;
    op_start = 1'b1; clks(1); op_start = 1'b0; clks(OPN + 10);
    chk(low_cnt == OPN, "R9 operation busy length", low_cnt, OPN);

    low_cnt = 0;
    op_start = 1'b1; clks(1); op_start = 1'b0; clks(30);
    wr(1, 8'hFF, 1); clks(TRST + 10);
    chk(rb_n === 1'b1, "R9 abort ends busy", rb_n, 1);
    chk(low_cnt < OPN && low_cnt > TRST, "R9 aborted busy shorter", low_cnt, OPN);
    chk(status === 8'hC0, "R7 status after abort", status, 8'hC0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule